// File: doc/BRIEF.md
# Timestamp Transaction Conflict Arbiter

This block decides which of two hardware transactions survives when both touch the same cache line and at least one of them writes it. Each of a small set of processors asks to begin a transaction and is given an age stamp. When a coherence request from one processor reaches a line held by another live transaction, the block compares the two stamps in the same cycle the request arrives. Either the requester is told to wait (a nack), or the holder is aborted. The decision is registered and appears one cycle later.

An age stamp is the value of a shared logical clock with the processor number appended as the low bits, so two stamps are never equal. The clock advances once for each cycle in which any processor starts a fresh transaction. A processor that was aborted keeps its stamp when it restarts. Over time it becomes the oldest transaction, so it cannot be starved. Each abort starts a backoff wait that the processor must sit out before it may begin again. The wait doubles with every abort that is not followed by a commit, and it is limited by a programmable cap.

Data versioning, rollback, the cache and the interconnect sit outside this block. The block sees only begin and commit strobes and conflict queries, and it returns decisions.

Top module: `tx_conflict_arbiter`

## Requirements
- R1: After reset no processor is active or busy, every stamp reads zero, and no result is valid.
- R2: A fresh begin for processor i loads stamp {clock, i}, where processor i's stamp sits at stamp_flat[i*TS_W +: TS_W] and the id occupies the low ID_W bits. Begins accepted in the same cycle share one clock value. The clock then advances by exactly one.
- R3: A begin is ignored while that processor is active or busy. An ignored begin does not change the processor's stamp and does not advance the clock.
- R4: A query is a conflict only when the requester and the holder are both active, they are different processors, and at least one of q_req_wr and q_hold_wr is 1. Two reads are never a conflict, and a query that is not a conflict returns neither nack nor abort.
- R5: On a conflict, if the requester's stamp is the smaller one, res_abort is raised with res_cpu set to the holder, and the holder becomes inactive. Otherwise res_nack is raised and no state changes.
- R6: Each query cycle produces exactly one res_vld pulse in the following cycle, and no pulse appears without a query.
- R7: A processor restarting after an abort keeps its earlier stamp, and the clock does not advance for that restart.
- R8: An abort makes the holder busy for D cycles, where D = min(delay, bo_cap). The delay starts at BO_MIN and becomes min(2*delay, bo_cap) after each abort.
- R9: A commit of an active processor makes it inactive, clears its retained stamp so that its next begin is fresh, and returns its delay to BO_MIN.
- R10: If the holder commits in the same cycle as a query against it, the commit takes effect and the query reports neither nack nor abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| begin_req | input | NCPU | Per-processor transaction begin strobe |
| commit_req | input | NCPU | Per-processor transaction commit strobe |
| q_vld | input | 1 | Conflict query valid |
| q_req_cpu | input | ID_W | Requesting processor |
| q_hold_cpu | input | ID_W | Processor holding the line |
| q_req_wr | input | 1 | Requester access is a write |
| q_hold_wr | input | 1 | Holder has written the line |
| bo_cap | input | BO_W | Upper limit on the backoff delay |
| res_vld | output | 1 | Decision valid (one cycle after the query) |
| res_nack | output | 1 | Requester must wait |
| res_abort | output | 1 | Holder is aborted |
| res_cpu | output | ID_W | Holder named by the decision |
| active | output | NCPU | Processor has a live transaction |
| busy | output | NCPU | Processor is sitting out a backoff wait |
| stamp_flat | output | NCPU*TS_W | Age stamps of all processors, packed |

## Verification
Two functions can land on the same processor in one cycle. A commit from the holder can coincide with a query that would abort it, and a begin can arrive while an abort's backoff is still running. The bench drives the commit strobe and the losing query in the same cycle. It then expects a clean result, an inactive holder and no backoff. It also issues a begin in the cycle right after an abort and expects the processor to stay inactive and the remaining wait to match the computed delay minus one. A scoreboard built from the stamp ordering judges every query decision.

// File: rtl/tsarb_pkg.sv
package tsarb_pkg;

  // Kind of access pair seen by a conflict query
  typedef enum logic [1:0] {
    ACC_CLEAN       = 2'd0,
    ACC_RD_AFTER_WR = 2'd1,
    ACC_WR_AFTER_RD = 2'd2,
    ACC_WR_AFTER_WR = 2'd3
  } acc_class_e;

  function automatic acc_class_e classify(input logic req_wr, input logic hold_wr);
    if (req_wr && hold_wr) return ACC_WR_AFTER_WR;
    if (req_wr)            return ACC_WR_AFTER_RD;
    if (hold_wr)           return ACC_RD_AFTER_WR;
    return ACC_CLEAN;
  endfunction

  function automatic logic is_conflict(input acc_class_e c);
    return c != ACC_CLEAN;
  endfunction

endpackage

// File: rtl/tsarb_stamps.sv
module tsarb_stamps #(
  parameter int NCPU  = 4,
  parameter int CLK_W = 6,
  parameter int ID_W  = 2,
  parameter int TS_W  = CLK_W + ID_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCPU-1:0]      begin_req,
  input  logic [NCPU-1:0]      commit_acc,
  input  logic [NCPU-1:0]      abort_vec,
  input  logic [NCPU-1:0]      busy,
  output logic [NCPU-1:0]      active,
  output logic [NCPU-1:0]      begin_acc,
  output logic [NCPU*TS_W-1:0] stamp_flat
);

  logic [CLK_W-1:0] lclk;
  logic [NCPU-1:0]  keep;
  logic [NCPU-1:0]  fresh;
  logic [TS_W-1:0]  ts_q [NCPU];

  function automatic logic [TS_W-1:0] make_stamp(input logic [CLK_W-1:0] c, input int id);
    return {c, ID_W'(id)};
  endfunction

  assign begin_acc = begin_req & ~active & ~busy;
  assign fresh     = begin_acc & ~keep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lclk   <= '0;
      keep   <= '0;
      active <= '0;
      for (int i = 0; i < NCPU; i++) ts_q[i] <= '0;
    end else begin
      if (|fresh) lclk <= lclk + 1'b1;
      active <= (active & ~abort_vec & ~commit_acc) | begin_acc;
      keep   <= (keep | abort_vec) & ~commit_acc;
      for (int i = 0; i < NCPU; i++) begin
        if (fresh[i]) ts_q[i] <= make_stamp(lclk, i);
      end
    end
  end

  for (genvar g = 0; g < NCPU; g++) begin : g_flat
    assign stamp_flat[g*TS_W +: TS_W] = ts_q[g];
  end

endmodule

// File: rtl/tsarb_backoff.sv
module tsarb_backoff #(
  parameter int NCPU   = 4,
  parameter int BO_W   = 8,
  parameter int BO_MIN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCPU-1:0] abort_vec,
  input  logic [NCPU-1:0] commit_acc,
  input  logic [BO_W-1:0] bo_cap,
  output logic [NCPU-1:0] busy
);

  localparam logic [BO_W-1:0] START = BO_W'(BO_MIN);

  logic [BO_W-1:0] cnt [NCPU];
  logic [BO_W-1:0] nxt [NCPU];

  function automatic logic [BO_W-1:0] load_delay(input logic [BO_W-1:0] cur, input logic [BO_W-1:0] cap);
    return (cur > cap) ? cap : cur;
  endfunction

  function automatic logic [BO_W-1:0] grow_delay(input logic [BO_W-1:0] cur, input logic [BO_W-1:0] cap);
    logic [BO_W:0] dbl;
    dbl = {cur, 1'b0};
    return (dbl > {1'b0, cap}) ? cap : dbl[BO_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCPU; i++) begin
        cnt[i] <= '0;
        nxt[i] <= START;
      end
    end else begin
      for (int i = 0; i < NCPU; i++) begin
        if (abort_vec[i]) begin
          cnt[i] <= load_delay(nxt[i], bo_cap);
          nxt[i] <= grow_delay(nxt[i], bo_cap);
        end else begin
          if (cnt[i] != '0) cnt[i] <= cnt[i] - 1'b1;
          if (commit_acc[i]) nxt[i] <= START;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NCPU; i++) busy[i] = (cnt[i] != '0);
  end

endmodule

// File: rtl/tsarb_decide.sv
module tsarb_decide
  import tsarb_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int ID_W = 2,
  parameter int TS_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 q_vld,
  input  logic [ID_W-1:0]      q_req_cpu,
  input  logic [ID_W-1:0]      q_hold_cpu,
  input  logic                 q_req_wr,
  input  logic                 q_hold_wr,
  input  logic [NCPU-1:0]      active,
  input  logic [NCPU-1:0]      commit_acc,
  input  logic [NCPU*TS_W-1:0] stamp_flat,
  output logic [NCPU-1:0]      abort_vec,
  output logic                 conflict_evt,
  output logic                 res_vld,
  output logic                 res_nack,
  output logic                 res_abort,
  output logic [ID_W-1:0]      res_cpu
);

  logic [TS_W-1:0] ts [NCPU];
  acc_class_e      cls;
  logic            hold_live;
  logic            req_live;
  logic            req_wins;

  function automatic logic stamp_before(input logic [TS_W-1:0] a, input logic [TS_W-1:0] b);
    return a < b;
  endfunction

  for (genvar g = 0; g < NCPU; g++) begin : g_unpack
    assign ts[g] = stamp_flat[g*TS_W +: TS_W];
  end

  assign cls = classify(q_req_wr, q_hold_wr);

  always_comb begin
    hold_live    = active[q_hold_cpu] & ~commit_acc[q_hold_cpu];
    req_live     = active[q_req_cpu];
    conflict_evt = q_vld & hold_live & req_live & (q_req_cpu != q_hold_cpu) & is_conflict(cls);
    req_wins     = stamp_before(ts[q_req_cpu], ts[q_hold_cpu]);
    abort_vec    = '0;
    if (conflict_evt && req_wins) abort_vec[q_hold_cpu] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld   <= 1'b0;
      res_nack  <= 1'b0;
      res_abort <= 1'b0;
      res_cpu   <= '0;
    end else begin
      res_vld   <= q_vld;
      res_nack  <= conflict_evt & ~req_wins;
      res_abort <= conflict_evt & req_wins;
      res_cpu   <= q_hold_cpu;
    end
  end

endmodule

// File: rtl/tx_conflict_arbiter.sv
module tx_conflict_arbiter #(
  parameter int NCPU   = 4,
  parameter int CLK_W  = 6,
  parameter int BO_W   = 8,
  parameter int BO_MIN = 2,
  localparam int ID_W  = $clog2(NCPU),
  localparam int TS_W  = CLK_W + ID_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCPU-1:0]      begin_req,
  input  logic [NCPU-1:0]      commit_req,
  input  logic                 q_vld,
  input  logic [ID_W-1:0]      q_req_cpu,
  input  logic [ID_W-1:0]      q_hold_cpu,
  input  logic                 q_req_wr,
  input  logic                 q_hold_wr,
  input  logic [BO_W-1:0]      bo_cap,
  output logic                 res_vld,
  output logic                 res_nack,
  output logic                 res_abort,
  output logic [ID_W-1:0]      res_cpu,
  output logic [NCPU-1:0]      active,
  output logic [NCPU-1:0]      busy,
  output logic [NCPU*TS_W-1:0] stamp_flat
);

  // Internal events, named for the checker
  logic [NCPU-1:0] commit_acc;
  logic [NCPU-1:0] begin_acc;
  logic [NCPU-1:0] abort_vec;
  logic            conflict_evt;

  assign commit_acc = commit_req & active;

  tsarb_stamps #(.NCPU(NCPU), .CLK_W(CLK_W), .ID_W(ID_W), .TS_W(TS_W)) u_stamps (
    .clk        (clk),
    .rst_n      (rst_n),
    .begin_req  (begin_req),
    .commit_acc (commit_acc),
    .abort_vec  (abort_vec),
    .busy       (busy),
    .active     (active),
    .begin_acc  (begin_acc),
    .stamp_flat (stamp_flat)
  );

  tsarb_decide #(.NCPU(NCPU), .ID_W(ID_W), .TS_W(TS_W)) u_decide (
    .clk          (clk),
    .rst_n        (rst_n),
    .q_vld        (q_vld),
    .q_req_cpu    (q_req_cpu),
    .q_hold_cpu   (q_hold_cpu),
    .q_req_wr     (q_req_wr),
    .q_hold_wr    (q_hold_wr),
    .active       (active),
    .commit_acc   (commit_acc),
    .stamp_flat   (stamp_flat),
    .abort_vec    (abort_vec),
    .conflict_evt (conflict_evt),
    .res_vld      (res_vld),
    .res_nack     (res_nack),
    .res_abort    (res_abort),
    .res_cpu      (res_cpu)
  );

  tsarb_backoff #(.NCPU(NCPU), .BO_W(BO_W), .BO_MIN(BO_MIN)) u_backoff (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort_vec  (abort_vec),
    .commit_acc (commit_acc),
    .bo_cap     (bo_cap),
    .busy       (busy)
  );

endmodule

// File: rtl/tsarb_checker.sv
module tsarb_checker #(
  parameter int NCPU = 4,
  parameter int ID_W = 2,
  parameter int TS_W = 8,
  parameter int BO_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NCPU-1:0]      commit_req,
  input logic                 q_vld,
  input logic [ID_W-1:0]      q_req_cpu,
  input logic [ID_W-1:0]      q_hold_cpu,
  input logic                 q_req_wr,
  input logic                 q_hold_wr,
  input logic [BO_W-1:0]      bo_cap,
  input logic                 res_vld,
  input logic                 res_nack,
  input logic                 res_abort,
  input logic [ID_W-1:0]      res_cpu,
  input logic [NCPU-1:0]      active,
  input logic [NCPU-1:0]      busy,
  input logic [NCPU*TS_W-1:0] stamp_flat,
  input logic [NCPU-1:0]      abort_vec,
  input logic [NCPU-1:0]      begin_acc,
  input logic                 conflict_evt
);

  logic [TS_W-1:0] ts_arr [NCPU];
  logic [TS_W-1:0] ts_req;
  logic [TS_W-1:0] ts_hold;

  for (genvar g = 0; g < NCPU; g++) begin : g_ts
    assign ts_arr[g] = stamp_flat[g*TS_W +: TS_W];
  end
  assign ts_req  = ts_arr[q_req_cpu];
  assign ts_hold = ts_arr[q_hold_cpu];

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> !(res_nack && res_abort)); // R5

  AST_SINGLE_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(abort_vec)); // R5

  AST_ABORT_IFF_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_vec != '0) |-> conflict_evt); // R4

  AST_RES_FOLLOWS_QUERY: assert property (@(posedge clk) disable iff (!rst_n)
    q_vld |=> res_vld); // R6

  AST_NO_STRAY_RES: assert property (@(posedge clk) disable iff (!rst_n)
    !q_vld |=> !res_vld); // R6

  AST_ABORT_OLDER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    q_vld ##1 res_abort |-> $past(ts_hold) > $past(ts_req)); // R5

  AST_NACK_YOUNGER_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    q_vld ##1 res_nack |-> $past(ts_req) > $past(ts_hold)); // R5

  AST_READ_READ_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (q_vld && !q_req_wr && !q_hold_wr) |=> (!res_nack && !res_abort)); // R4

  AST_ABORT_DROPS_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
    res_abort |-> !active[res_cpu]); // R5

  AST_COMMIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (q_vld && commit_req[q_hold_cpu] && active[q_hold_cpu]) |=> (!res_abort && !res_nack)); // R10

  AST_ABORT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (q_vld && bo_cap != '0) ##1 res_abort |-> busy[res_cpu]); // R8

  for (genvar g = 0; g < NCPU; g++) begin : g_cpu
    AST_BEGIN_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active[g]) |-> !$past(busy[g])); // R3
    AST_BEGIN_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      begin_acc[g] |=> active[g]); // R3
  end

endmodule

bind tx_conflict_arbiter tsarb_checker #(
  .NCPU(NCPU), .ID_W(ID_W), .TS_W(TS_W), .BO_W(BO_W)
) u_tsarb_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .commit_req   (commit_req),
  .q_vld        (q_vld),
  .q_req_cpu    (q_req_cpu),
  .q_hold_cpu   (q_hold_cpu),
  .q_req_wr     (q_req_wr),
  .q_hold_wr    (q_hold_wr),
  .bo_cap       (bo_cap),
  .res_vld      (res_vld),
  .res_nack     (res_nack),
  .res_abort    (res_abort),
  .res_cpu      (res_cpu),
  .active       (active),
  .busy         (busy),
  .stamp_flat   (stamp_flat),
  .abort_vec    (abort_vec),
  .begin_acc    (begin_acc),
  .conflict_evt (conflict_evt)
);

// File: tb/tx_conflict_arbiter_bench.sv
`timescale 1ns/1ps
module tx_conflict_arbiter_bench;

  localparam int NCPU = 4;
  localparam int TSW  = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [3:0]     begin_req = '0;
  logic [3:0]     commit_req = '0;
  logic           q_vld = 1'b0;
  logic [1:0]     q_req_cpu = '0;
  logic [1:0]     q_hold_cpu = '0;
  logic           q_req_wr = 1'b0;
  logic           q_hold_wr = 1'b0;
  logic [7:0]     bo_cap = 8'd16;
  logic           res_vld, res_nack, res_abort;
  logic [1:0]     res_cpu;
  logic [3:0]     active, busy;
  logic [31:0]    stamp_flat;

  always #2 clk = ~clk;

  tx_conflict_arbiter u_tx_conflict_arbiter (
    .clk(clk), .rst_n(rst_n), .begin_req(begin_req), .commit_req(commit_req),
    .q_vld(q_vld), .q_req_cpu(q_req_cpu), .q_hold_cpu(q_hold_cpu),
    .q_req_wr(q_req_wr), .q_hold_wr(q_hold_wr), .bo_cap(bo_cap),
    .res_vld(res_vld), .res_nack(res_nack), .res_abort(res_abort), .res_cpu(res_cpu),
    .active(active), .busy(busy), .stamp_flat(stamp_flat)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  typedef struct { bit nack; bit abort; int cpu; string tag; } exp_t;
  exp_t sb [$];

  // Reference model state
  bit m_act [NCPU];
  bit m_keep [NCPU];
  int m_ts [NCPU];
  int m_bcnt [NCPU];
  int m_next [NCPU];
  int m_clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // One clock of stimulus; expected decisions go to the scoreboard
  task automatic step(input logic [3:0] bg, input logic [3:0] cm, input bit qv,
                      input int r, input int h, input bit rw, input bit hw, input string tag);
    bit commit_eff [NCPU];
    bit conflict, wins;
    exp_t e;
    @(negedge clk);
    begin_req = bg; commit_req = cm; q_vld = qv;
    q_req_cpu = r[1:0]; q_hold_cpu = h[1:0]; q_req_wr = rw; q_hold_wr = hw;
    for (int i = 0; i < NCPU; i++) commit_eff[i] = cm[i] && m_act[i];
    conflict = qv && m_act[r] && m_act[h] && !commit_eff[h] && (r != h) && (rw || hw);
    wins = m_ts[r] < m_ts[h];
    if (qv) begin
      e.nack = conflict && !wins; e.abort = conflict && wins; e.cpu = h; e.tag = tag;
      sb.push_back(e);
    end
    @(posedge clk);
    #1;
    begin_req = '0; commit_req = '0; q_vld = 1'b0;
    begin
      bit fresh_any;
      fresh_any = 0;
      for (int i = 0; i < NCPU; i++) begin
        bit acc;
        acc = bg[i] && !m_act[i] && (m_bcnt[i] == 0);
        if (commit_eff[i]) begin
          m_act[i] = 0; m_keep[i] = 0; m_next[i] = 2;
        end
        if (m_bcnt[i] > 0) m_bcnt[i]--;
        if (acc) begin
          m_act[i] = 1;
          if (!m_keep[i]) begin
            m_ts[i] = (m_clk % 64) * 4 + i;
            fresh_any = 1;
          end
        end
      end
      if (fresh_any) m_clk++;
      if (conflict && wins) begin
        m_act[h] = 0; m_keep[h] = 1;
        m_bcnt[h] = min2(m_next[h], int'(bo_cap));
        m_next[h] = min2(2 * m_next[h], int'(bo_cap));
      end
    end
  endtask

  task automatic query(input int r, input int h, input bit rw, input bit hw, input string tag);
    step(4'b0000, 4'b0000, 1'b1, r, h, rw, hw, tag);
  endtask

  task automatic start(input logic [3:0] bg, input string tag);
    step(bg, 4'b0000, 1'b0, 0, 0, 1'b0, 1'b0, tag);
  endtask

  task automatic chk_stamps(input string tag);
    for (int i = 0; i < NCPU; i++)
      check(int'(stamp_flat[i*TSW +: TSW]) == m_ts[i], tag, int'(stamp_flat[i*TSW +: TSW]), m_ts[i]);
  endtask

  task automatic chk_active(input string tag);
    for (int i = 0; i < NCPU; i++)
      check(active[i] == m_act[i], tag, int'(active[i]), int'(m_act[i]));
  endtask

  // Count the cycles a processor stays busy; must equal the model delay
  task automatic expect_delay(input int c, input string tag);
    int n;
    int want;
    want = m_bcnt[c];
    n = 0;
    while (busy[c] && n < 300) begin
      start(4'b0000, tag);
      n++;
    end
    check(n == want, tag, n, want);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && res_vld) begin
      if (sb.size() == 0) begin
        tests++; fails++;
        $display("FAIL R6 unexpected result actual=1 expected=0");
      end else begin
        exp_t e;
        bit ok;
        e = sb.pop_front();
        ok = (res_nack == e.nack) && (res_abort == e.abort) && (!e.abort || int'(res_cpu) == e.cpu);
        check(ok, e.tag, {res_nack, res_abort, res_cpu}, {e.nack, e.abort, e.cpu[1:0]});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCPU; i++) begin
      m_act[i] = 0; m_keep[i] = 0; m_ts[i] = 0; m_bcnt[i] = 0; m_next[i] = 2;
    end
    m_clk = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(active == 4'b0, "R1 active", int'(active), 0);
    check(busy == 4'b0, "R1 busy", int'(busy), 0);
    check(stamp_flat == '0, "R1 stamps", int'(stamp_flat), 0);
    check(res_vld == 1'b0, "R1 res_vld", int'(res_vld), 0);

    // R2 stamps and shared clock
    start(4'b0001, "R2 begin0");
    start(4'b0110, "R2 begin12");
    chk_stamps("R2 stamps");
    check(int'(stamp_flat[15:8]) == 5, "R2 cpu1 stamp", int'(stamp_flat[15:8]), 5);
    // R3 ignored begin does not move the clock
    start(4'b1001, "R3 begin03");
    check(int'(stamp_flat[31:24]) == 11, "R3 clock held", int'(stamp_flat[31:24]), 11);
    chk_stamps("R3 stamps");

    // R4 classification
    query(1, 0, 1'b0, 1'b0, "R4 read-read");
    query(1, 1, 1'b1, 1'b1, "R4 same cpu");

    // R5 older requester aborts holder, R8 backoff
    query(0, 1, 1'b1, 1'b0, "R5 abort cpu1");
    chk_active("R5 active after abort");
    start(4'b0010, "R3 begin while busy");
    check(active[1] == 1'b0, "R3 busy begin ignored", int'(active[1]), 0);
    expect_delay(1, "R8 delay cpu1");
    start(4'b0010, "R7 restart cpu1");
    chk_stamps("R7 kept stamp");
    check(int'(stamp_flat[15:8]) == 5, "R7 cpu1 stamp", int'(stamp_flat[15:8]), 5);

    // R5 younger requester is nacked
    query(2, 1, 1'b0, 1'b1, "R5 nack cpu2");
    chk_active("R5 nack leaves state");

    // R8 doubling and cap
    for (int k = 0; k < 3; k++) begin
      query(1, 2, 1'b1, 1'b0, "R8 abort cpu2");
      expect_delay(2, "R8 doubled delay");
      start(4'b0100, "R7 restart cpu2");
    end
    bo_cap = 8'd5;
    query(1, 2, 1'b1, 1'b0, "R8 capped abort");
    check(m_bcnt[2] == 5, "R8 model cap", m_bcnt[2], 5);
    expect_delay(2, "R8 capped delay");
    start(4'b0100, "R7 restart cpu2");
    chk_stamps("R7 stamps after restarts");

    // R9 commit resets retained stamp and delay
    step(4'b0000, 4'b0100, 1'b0, 0, 0, 1'b0, 1'b0, "R9 commit cpu2");
    chk_active("R9 commit");
    start(4'b0100, "R9 fresh begin");
    chk_stamps("R9 fresh stamp");
    query(1, 2, 1'b1, 1'b1, "R9 abort after commit");
    expect_delay(2, "R9 delay reset");

    // R10 commit wins over same-cycle abort
    step(4'b0000, 4'b1000, 1'b1, 0, 3, 1'b1, 1'b0, "R10 commit vs query");
    chk_active("R10 holder committed");
    check(busy[3] == 1'b0, "R10 no backoff", int'(busy[3]), 0);
    query(3, 0, 1'b1, 1'b1, "R4 inactive requester");

    // R5 write-write, younger requester
    start(4'b1000, "R2 begin3");
    chk_stamps("R2 stamp3");
    query(3, 0, 1'b1, 1'b1, "R5 write-write nack");
    query(2, 0, 1'b0, 1'b0, "R4 read-read again");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R6 all results seen", sb.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule